// File: doc/BRIEF.md
# Audio Clock Ratio and Rate Detector

This block runs on the master system clock and watches an asynchronous frame (word-select) clock. It measures two things. The first is the number of master-clock cycles between successive rising frame edges, which it maps to one of the supported master-clock-to-sample-rate ratios. The second is the number of frame edges seen inside a gate window. A reference pulse, `gate_tick`, marks the end of each window. From that count the block derives the sample-rate band and the exact rate within the band.

When three measurements in a row agree, the block asserts `locked`. It then copies the band onto `clk_mode`, which drives the filter, modulator and charge-pump clocking mode directly, with no software involved. An error flag reports an unsupported ratio, a rate outside every tolerance window, or a frame clock that has gone silent. A separate flag marks the two rates (44.1 kHz and 48 kHz) that the downstream processing path accepts. The block has no streaming data interface. Every pin is a plain control or status signal.

The gate window length is the parameter `GATE_UNITS`, counted in steps of 100 µs (the default of 100 gives 10 ms). A rate of R Hz is expected to give R·GATE_UNITS/10000 edges per window.

Top module: `audio_clk_detector`

## Requirements
- R1: After each rising frame edge, `ratio_code` reports the measured period as follows: 128→0, 192→1, 256→2, 384→3, 512→4, 768→5, 1024→6, each within ±RATIO_TOL master cycles. Any other period, or the first period after a timeout, gives 7.
- R2: At each `gate_tick`, the frame-edge count of the window that just closed sets `band_code`. A count matches a nominal rate only if it lies within ±4 % of that rate's expected count. The codes are: 0 = 8 kHz, 1 = 16 kHz, 2 = single (32/44.1/48 kHz), 3 = double (88.2/96 kHz), 4 = quad (176.4/192 kHz), 5 = 384 kHz, 7 = no window matched.
- R3: Rates within one group share a band code. `fine_code` tells the members apart using non-overlapping windows: 1 = 44.1 kHz family (44.1/88.2/176.4), 2 = 48 kHz family (48/96/192), 0 = 8, 16, 32 or 384 kHz, 3 = no match.
- R4: `locked` rises once LOCK_COUNT (default 3) consecutive window measurements are valid and have identical ratio and band codes.
- R5: The first invalid or disagreeing measurement clears `locked`. While unlocked, `clk_mode` holds its last value.
- R6: `proc_ok` is 1 only while locked on a 44.1 kHz or 48 kHz rate (band 2, fine 1 or 2). It is 0 for every other rate, including 32 kHz and 96 kHz.
- R7: `err` is 1 after a window whose measurement had an unsupported ratio or an unmatched band, and stays 1 until a valid window.
- R8: If no synchronised frame edge arrives for TIMEOUT (default 2048) master cycles, `err` rises and `locked` and `proc_ok` clear.
- R9: `clk_mode` takes the band code at the moment lock is reached, and at no other time.
- R10: After reset: `ratio_code`=7, `band_code`=7, `fine_code`=3, `locked`=0, `proc_ok`=0, `err`=0, `clk_mode`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Asynchronous frame (word-select) clock |
| gate_tick | input | 1 | One-cycle pulse ending each gate window |
| ratio_code | output | 3 | Master-clock ratio code |
| band_code | output | 3 | Sample-rate band code |
| fine_code | output | 2 | Rate family within the band |
| locked | output | 1 | Measurements stable |
| err | output | 1 | Unsupported ratio, unmatched rate or frame timeout |
| proc_ok | output | 1 | Locked on 44.1 kHz or 48 kHz |
| clk_mode | output | 3 | Filter/modulator/charge-pump clock mode |

## Verification
- **Band and fine codes:** these are registered one cycle after the `gate_tick` edge.
- **Lock, mode and error:** `locked`, `proc_ok`, `clk_mode` and the window part of `err` follow one cycle after the band and fine codes.
- **Ratio code:** `ratio_code` follows a frame edge by the two synchroniser stages, the edge stage and one register.
- **Timeout:** the timeout flag rises TIMEOUT cycles after the last detected edge.

The bench sets each gate length to an exact multiple of the frame period, so the edge count per window is exact. It treats the first window after any change as unsettled. It samples results on a falling edge three cycles after the last gate pulse of a scenario, by which time every result is due. The timeout is checked 2200 cycles after the frame clock stops.

// File: rtl/acd_pkg.sv
package acd_pkg;
  localparam logic [2:0] RATIO_NONE  = 3'd7;
  localparam logic [2:0] BAND_NONE   = 3'd7;
  localparam logic [2:0] BAND_SINGLE = 3'd2;
  localparam logic [1:0] FINE_OTHER  = 2'd0;
  localparam logic [1:0] FINE_441    = 2'd1;
  localparam logic [1:0] FINE_48     = 2'd2;
  localparam logic [1:0] FINE_NONE   = 2'd3;
  localparam int NUM_RATIOS = 7;
  localparam int NUM_RATES  = 10;

  typedef struct packed {
    logic [2:0] band;
    logic [1:0] fine;
  } rate_t;

  function automatic int unsigned ratio_nominal(int idx);
    case (idx)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      5: return 768;
      default: return 1024;
    endcase
  endfunction

  function automatic logic [2:0] ratio_classify(int unsigned period, int unsigned tol);
    logic [2:0] code;
    code = RATIO_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if ((period + tol >= ratio_nominal(i)) && (period <= ratio_nominal(i) + tol))
        code = 3'(i);
    end
    return code;
  endfunction

  function automatic int unsigned rate_hz(int idx);
    case (idx)
      0: return 8000;
      1: return 16000;
      2: return 32000;
      3: return 44100;
      4: return 48000;
      5: return 88200;
      6: return 96000;
      7: return 176400;
      8: return 192000;
      default: return 384000;
    endcase
  endfunction

  function automatic rate_t rate_group(int idx);
    case (idx)
      0: return '{band: 3'd0, fine: FINE_OTHER};
      1: return '{band: 3'd1, fine: FINE_OTHER};
      2: return '{band: 3'd2, fine: FINE_OTHER};
      3: return '{band: 3'd2, fine: FINE_441};
      4: return '{band: 3'd2, fine: FINE_48};
      5: return '{band: 3'd3, fine: FINE_441};
      6: return '{band: 3'd3, fine: FINE_48};
      7: return '{band: 3'd4, fine: FINE_441};
      8: return '{band: 3'd4, fine: FINE_48};
      default: return '{band: 3'd5, fine: FINE_OTHER};
    endcase
  endfunction

  // Count is compared in hundredths of an edge against +/-4 % of nominal.
  function automatic rate_t rate_classify(int unsigned edges, int unsigned gate_units);
    rate_t res;
    int unsigned scaled;
    int unsigned nom_c;
    res = '{band: BAND_NONE, fine: FINE_NONE};
    scaled = edges * 32'd10000;
    for (int i = 0; i < NUM_RATES; i++) begin
      nom_c = rate_hz(i) * gate_units / 32'd100;
      if ((scaled >= nom_c * 32'd96) && (scaled <= nom_c * 32'd104))
        res = rate_group(i);
    end
    return res;
  endfunction
endpackage

// File: rtl/acd_frame_sync.sv
module acd_frame_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_async,
  output logic rise_pulse
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], frame_async};
  end

  assign rise_pulse = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/acd_period_meter.sv
module acd_period_meter
  import acd_pkg::*;
#(
  parameter int TIMEOUT   = 2048,
  parameter int RATIO_TOL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_pulse,
  output logic [2:0] ratio_code,
  output logic       timeout
);
  localparam int W = $clog2(TIMEOUT + 1);
  localparam logic [W-1:0] CNT_LAST = W'(TIMEOUT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      ratio_code <= RATIO_NONE;
      timeout    <= 1'b0;
    end else if (rise_pulse) begin
      ratio_code <= timeout ? RATIO_NONE
                            : ratio_classify(32'(cnt) + 32'd1, 32'(RATIO_TOL));
      cnt        <= '0;
      timeout    <= 1'b0;
    end else if (cnt == CNT_LAST) begin
      timeout    <= 1'b1;
    end else begin
      cnt        <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST); // R8
  AST_EDGE_CLEARS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !timeout); // R8
  AST_RATIO_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_pulse |=> $stable(ratio_code)); // R1
endmodule

// File: rtl/acd_rate_meter.sv
module acd_rate_meter
  import acd_pkg::*;
#(
  parameter int GATE_UNITS = 100,
  parameter int CNT_W      = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_pulse,
  input  logic  gate_tick,
  output rate_t meas,
  output logic  meas_stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = (rise_pulse && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      meas     <= '{band: BAND_NONE, fine: FINE_NONE};
      meas_stb <= 1'b0;
    end else begin
      meas_stb <= gate_tick;
      if (gate_tick) begin
        meas <= rate_classify(32'(cnt_next), 32'(GATE_UNITS));
        cnt  <= '0;
      end else begin
        cnt  <= cnt_next;
      end
    end
  end

  AST_BAND_ONLY_AT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_tick |=> $stable(meas)); // R2
  AST_FINE_IN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (meas.fine == FINE_441 || meas.fine == FINE_48) |-> (meas.band inside {3'd2, 3'd3, 3'd4})); // R3
endmodule

// File: rtl/acd_lock_tracker.sv
module acd_lock_tracker
  import acd_pkg::*;
#(
  parameter int LOCK_COUNT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_stb,
  input  rate_t      meas,
  input  logic [2:0] ratio_code,
  input  logic       timeout,
  output logic       locked,
  output logic       proc_ok,
  output logic       err,
  output logic [2:0] clk_mode
);
  localparam int SW = $clog2(LOCK_COUNT + 1);
  localparam logic [SW-1:0] STREAK_FULL = SW'(LOCK_COUNT);

  logic [SW-1:0] streak;
  logic [SW-1:0] streak_next;
  logic [2:0]    prev_band;
  logic [2:0]    prev_ratio;
  logic          meas_bad;
  logic          valid;
  logic          same;

  always_comb begin
    valid = (meas.band != BAND_NONE) && (ratio_code != RATIO_NONE);
    same  = valid && (streak != '0) && (meas.band == prev_band) && (ratio_code == prev_ratio);
    if (!valid)
      streak_next = '0;
    else if (same)
      streak_next = (streak == STREAK_FULL) ? streak : streak + 1'b1;
    else
      streak_next = SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak     <= '0;
      prev_band  <= BAND_NONE;
      prev_ratio <= RATIO_NONE;
      meas_bad   <= 1'b0;
      locked     <= 1'b0;
      proc_ok    <= 1'b0;
      clk_mode   <= BAND_SINGLE;
    end else if (timeout) begin
      streak     <= '0;
      locked     <= 1'b0;
      proc_ok    <= 1'b0;
    end else if (meas_stb) begin
      streak     <= streak_next;
      prev_band  <= meas.band;
      prev_ratio <= ratio_code;
      meas_bad   <= !valid;
      locked     <= (streak_next == STREAK_FULL);
      proc_ok    <= (streak_next == STREAK_FULL) && (meas.band == BAND_SINGLE) &&
                    (meas.fine == FINE_441 || meas.fine == FINE_48);
      if (streak_next == STREAK_FULL) clk_mode <= meas.band;
    end
  end

  assign err = timeout | meas_bad;

  AST_LOCK_AFTER_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_stb)); // R4
  AST_MODE_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_mode) |-> locked); // R9
  AST_PROC_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    proc_ok |-> (locked && clk_mode == BAND_SINGLE)); // R6
  AST_TIMEOUT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (!locked && !proc_ok)); // R8
  AST_BAD_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    meas_bad |-> !locked); // R5
endmodule

// File: rtl/audio_clk_detector.sv
module audio_clk_detector
  import acd_pkg::*;
#(
  parameter int GATE_UNITS = 100,
  parameter int TIMEOUT    = 2048,
  parameter int RATIO_TOL  = 2,
  parameter int LOCK_COUNT = 3,
  parameter int EDGE_CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk,
  input  logic       gate_tick,
  output logic [2:0] ratio_code,
  output logic [2:0] band_code,
  output logic [1:0] fine_code,
  output logic       locked,
  output logic       err,
  output logic       proc_ok,
  output logic [2:0] clk_mode
);
  logic  rise_pulse;
  logic  timeout;
  logic  meas_stb;
  rate_t meas;

  acd_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .frame_async(frame_clk), .rise_pulse(rise_pulse)
  );

  acd_period_meter #(.TIMEOUT(TIMEOUT), .RATIO_TOL(RATIO_TOL)) u_period (
    .clk(clk), .rst_n(rst_n), .rise_pulse(rise_pulse),
    .ratio_code(ratio_code), .timeout(timeout)
  );

  acd_rate_meter #(.GATE_UNITS(GATE_UNITS), .CNT_W(EDGE_CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .rise_pulse(rise_pulse), .gate_tick(gate_tick),
    .meas(meas), .meas_stb(meas_stb)
  );

  acd_lock_tracker #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .meas_stb(meas_stb), .meas(meas),
    .ratio_code(ratio_code), .timeout(timeout), .locked(locked),
    .proc_ok(proc_ok), .err(err), .clk_mode(clk_mode)
  );

  assign band_code = meas.band;
  assign fine_code = meas.fine;
endmodule

// File: tb/audio_clk_detector_bench.sv
`timescale 1ns/1ps
module audio_clk_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic       gate_tick = 1'b0;
  logic [2:0] ratio_code, band_code, clk_mode;
  logic [1:0] fine_code;
  logic       locked, err, proc_ok;

  int checks = 0;
  int errors = 0;
  int half = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_clk_detector #(.GATE_UNITS(5)) u_audio_clk_detector (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .gate_tick(gate_tick),
    .ratio_code(ratio_code), .band_code(band_code), .fine_code(fine_code),
    .locked(locked), .err(err), .proc_ok(proc_ok), .clk_mode(clk_mode)
  );

  // Frame clock generator: half == 0 holds it low.
  initial begin
    forever begin
      if (half == 0) begin
        frame_clk = 1'b0;
        @(negedge clk);
      end else begin
        frame_clk = 1'b1;
        repeat (half) @(negedge clk);
        frame_clk = 1'b0;
        repeat (half) @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_gates(input int gate_len, input int n);
    for (int g = 0; g < n; g++) begin
      repeat (gate_len - 1) @(negedge clk);
      gate_tick = 1'b1;
      @(negedge clk);
      gate_tick = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10", "ratio_code", ratio_code, 7);
    chk("R10", "band_code", band_code, 7);
    chk("R10", "fine_code", fine_code, 3);
    chk("R10", "locked", locked, 0);
    chk("R10", "proc_ok", proc_ok, 0);
    chk("R10", "err", err, 0);
    chk("R10", "clk_mode", clk_mode, 2);
  endtask

  task automatic t_48k_r256;
    half = 128;
    run_gates(24 * 256, 4);
    chk("R1", "ratio 256", ratio_code, 2);
    chk("R2", "band 48k", band_code, 2);
    chk("R3", "fine 48k", fine_code, 2);
    chk("R4", "locked 48k", locked, 1);
    chk("R6", "proc_ok 48k", proc_ok, 1);
    chk("R9", "mode 48k", clk_mode, 2);
    chk("R7", "err 48k", err, 0);
  endtask

  task automatic t_441k_r128;
    half = 64;
    run_gates(22 * 128, 4);
    chk("R1", "ratio 128", ratio_code, 0);
    chk("R3", "fine 44.1k", fine_code, 1);
    chk("R4", "locked 44.1k", locked, 1);
    chk("R6", "proc_ok 44.1k", proc_ok, 1);
  endtask

  task automatic t_96k_r128;
    half = 64;
    run_gates(48 * 128, 4);
    chk("R2", "band 96k", band_code, 3);
    chk("R3", "fine 96k", fine_code, 2);
    chk("R6", "proc_ok 96k", proc_ok, 0);
    chk("R9", "mode 96k", clk_mode, 3);
  endtask

  task automatic t_timeout;
    half = 0;
    repeat (2200) @(negedge clk);
    chk("R8", "err timeout", err, 1);
    chk("R8", "locked timeout", locked, 0);
    chk("R5", "mode held timeout", clk_mode, 3);
  endtask

  task automatic t_8k_r1024;
    half = 512;
    run_gates(4 * 1024, 4);
    chk("R1", "ratio 1024", ratio_code, 6);
    chk("R2", "band 8k", band_code, 0);
    chk("R3", "fine 8k", fine_code, 0);
    chk("R9", "mode 8k", clk_mode, 0);
    chk("R8", "err cleared", err, 0);
  endtask

  task automatic t_bad_ratio;
    half = 150;
    run_gates(24 * 300, 2);
    chk("R1", "ratio 300", ratio_code, 7);
    chk("R7", "err bad ratio", err, 1);
    chk("R5", "locked bad ratio", locked, 0);
    chk("R5", "mode held bad ratio", clk_mode, 0);
  endtask

  task automatic t_bad_rate;
    half = 128;
    run_gates(20 * 256, 2);
    chk("R2", "band unmatched", band_code, 7);
    chk("R3", "fine unmatched", fine_code, 3);
    chk("R7", "err unmatched", err, 1);
    chk("R5", "mode held unmatched", clk_mode, 0);
  endtask

  task automatic t_32k_r384;
    half = 192;
    run_gates(16 * 384, 4);
    chk("R1", "ratio 384", ratio_code, 3);
    chk("R2", "band 32k", band_code, 2);
    chk("R3", "fine 32k", fine_code, 0);
    chk("R4", "locked 32k", locked, 1);
    chk("R6", "proc_ok 32k", proc_ok, 0);
    chk("R7", "err 32k", err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_48k_r256();
    t_441k_r128();
    t_96k_r128();
    t_timeout();
    t_8k_r1024();
    t_bad_ratio();
    t_bad_rate();
    t_32k_r384();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule